// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management frames towards Ethernet PHYs. Software writes one 32-bit command word that selects a PHY address, a register address and either a read or a write. The block then produces the whole serial frame on MDC and MDIO. A frame starts with a run of ones, then the start pattern, opcode, both addresses and the turnaround. After that it either drives sixteen write bits or releases the line and shifts in sixteen read bits. When the frame ends, a completion flag is raised for software to poll. For a read, the captured value appears in the low half of the same word.

The MDIO pin is split into an output, an output enable and an input, so the pad and the pull-up stay outside. MDC comes from a clock divider set by a parameter and is held low between frames.

A second entry point, a scan pulse, searches for an attached PHY. It reads the identifier register (register 3) at every address from 0 upwards, with no idle time between frames. It stops at the first address that returns something other than all-zeros or all-ones. If no address qualifies, it reports not-found and falls back to address 1. The scan uses the same frame engine as software commands, and the command word is left as it was.

Top module: `mdio_master`

## Requirements
- R1: A register write is accepted only while idle and only if bit 27 (read request) or bit 26 (write request) is set. If both bits are set, a read is performed. A word with neither bit set leaves the block idle and leaves every read-back field unchanged.
- R2: The read-back word carries the PHY address in bits 25:21, the register address in bits 20:16, the data in bits 15:0, the done flag in bit 28 and the busy flag in bit 29. All other bits read as zero.
- R3: Every frame drives PREAMBLE_LEN ones (35 by default), then the start bits 0,1, then the opcode (1,0 for a read, 0,1 for a write), then the 5-bit PHY address MSB first, then the 5-bit register address MSB first.
- R4: A write frame continues with the turnaround bits 1,0 and then the 16 data bits MSB first. The output enable stays high for all PREAMBLE_LEN+32 bits.
- R5: A read frame drops the output enable for one turnaround bit. It then samples 16 bits MSB first on MDC rising edges, and the sampled value replaces the data field when the frame ends. A read frame lasts PREAMBLE_LEN+31 bits.
- R6: Each bit lasts 2*CLK_DIV clock cycles: MDC is low for the first half and high for the second. The output and the output enable change only when a new bit starts, never while MDC is high. Between frames, MDC and the output enable are low and the output rests high.
- R7: Busy is high from the clock edge that accepts a command or a scan until the edge that ends the last frame. Command writes and scan pulses that arrive while busy are ignored.
- R8: Accepting a command clears the done flag. The edge that ends that command's frame sets done, for both reads and writes.
- R9: A scan pulse while idle reads register 3 at PHY addresses 0, 1, 2, … in order, with frames back to back. It stops at the first value that is neither 0x0000 nor 0xFFFF, and then reports found=1, that address, and scan-done=1.
- R10: If none of the 32 addresses qualifies, the scan ends after 32 frames with found=0, address 1 and scan-done=1.
- R11: A scan changes neither the command fields nor the done flag of the read-back word.
- R12: After reset the read-back word is zero, MDC and the output enable are low, the output is high, found and scan-done are low, and the reported scan address is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for the command word |
| regWrData | input | 32 | Command word being written |
| regRdData | output | 32 | Command/status word read back |
| scanStart | input | 1 | One-cycle pulse that starts a PHY address search |
| scanDone | output | 1 | Search has finished since it was last started |
| scanFound | output | 1 | Search found a PHY returning a valid identifier |
| scanAddr | output | 5 | Address found, or 1 when nothing answered |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data driven towards the PHY |
| mdioOe | output | 1 | Drive enable for the data pin |
| mdioIn | input | 1 | Data returned from the pin |

## Verification
The bench builds the block with CLK_DIV=2 and the default 35-bit preamble. That gives a four-cycle bit with distinct low and high halves, so a sample or an output change that lands one cycle off is visible. It also keeps a full 32-address search near eight thousand cycles, short enough to run a search that fails everywhere and one that succeeds only at address 31. The reference model drives the PHY's answer bits from its own bit timeline. Any shift in where the turnaround is released or where read bits are captured therefore shows up as a wrong data field as well as wrong pin values.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic load;     // start a new frame: load shifter, present first bit
    logic fall;     // MDC falls, next bit is presented
    logic rise;     // MDC rises
    logic capture;  // shift mdioIn into the receive register
    logic finish;   // frame over: park the pins
    logic drive;    // output enable for the bit presented on fall
  } mdio_strobe_t;

  localparam int DATA_W = 16;
  localparam logic [4:0] ID_REG_ADDR = 5'd3;
  localparam logic [4:0] FALLBACK_PHY = 5'd1;
  localparam logic [4:0] LAST_PHY = 5'd31;

endpackage

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 35
) (
  input  logic               clk,
  input  logic               rstN,
  input  mdio_strobe_t       stb,
  input  logic [4:0]         loadPhy,
  input  logic [4:0]         loadReg,
  input  logic               loadRead,
  input  logic [DATA_W-1:0]  loadData,
  input  logic               mdioIn,
  output logic               mdc,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic [DATA_W-1:0]  rxData
);

  localparam int FRAME_W = PREAMBLE_LEN + 32;
  localparam int TAIL_W  = DATA_W + 2;

  logic [FRAME_W-1:0] frameVec;
  logic [TAIL_W-1:0]  tailBits;
  logic [FRAME_W-2:0] shiftQ;   // bits still to be presented after the current one

  always_comb begin
    tailBits = loadRead ? {TAIL_W{1'b1}} : {2'b10, loadData};
    frameVec = {{PREAMBLE_LEN{1'b1}}, 2'b01, (loadRead ? 2'b10 : 2'b01),
                loadPhy, loadReg, tailBits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '1;
      mdc     <= 1'b0;
      mdioOut <= 1'b1;
      mdioOe  <= 1'b0;
    end else if (stb.load) begin
      shiftQ  <= frameVec[FRAME_W-2:0];
      mdioOut <= frameVec[FRAME_W-1];
      mdioOe  <= 1'b1;
      mdc     <= 1'b0;
    end else if (stb.fall) begin
      shiftQ  <= {shiftQ[FRAME_W-3:0], 1'b1};
      mdioOut <= shiftQ[FRAME_W-2];
      mdioOe  <= stb.drive;
      mdc     <= 1'b0;
    end else if (stb.rise) begin
      mdc <= 1'b1;
    end else if (stb.finish) begin
      mdc     <= 1'b0;
      mdioOe  <= 1'b0;
      mdioOut <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (stb.capture) begin
      rxData <= {rxData[DATA_W-2:0], mdioIn};
    end
  end

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV      = 10,
  parameter int PREAMBLE_LEN = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              wrRead,
  input  logic              wrWrite,
  input  logic [4:0]        wrPhy,
  input  logic [4:0]        wrReg,
  input  logic [DATA_W-1:0] wrData,
  input  logic              scanStart,
  input  logic [DATA_W-1:0] rxData,
  output mdio_strobe_t      stb,
  output logic [4:0]        loadPhy,
  output logic [4:0]        loadReg,
  output logic              loadRead,
  output logic              busy,
  output logic              done,
  output logic [4:0]        cmdPhy,
  output logic [4:0]        cmdReg,
  output logic [DATA_W-1:0] cmdData,
  output logic              scanDone,
  output logic              scanFound,
  output logic [4:0]        scanAddr
);

  localparam int PH_W    = (2 * CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
  localparam int WR_BITS = PREAMBLE_LEN + 32;
  localparam int RD_BITS = WR_BITS - 1;
  localparam int BIT_W   = $clog2(WR_BITS + 1);

  localparam logic [PH_W-1:0]  PH_MID       = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0]  PH_END       = PH_W'(2 * CLK_DIV - 1);
  localparam logic [BIT_W-1:0] WR_LAST      = BIT_W'(WR_BITS - 1);
  localparam logic [BIT_W-1:0] RD_LAST      = BIT_W'(RD_BITS - 1);
  localparam logic [BIT_W-1:0] RD_DRIVEN    = BIT_W'(PREAMBLE_LEN + 14);
  localparam logic [BIT_W-1:0] RD_FIRST_SMP = BIT_W'(PREAMBLE_LEN + 15);

  logic             running, scanning, cmdRead;
  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bitIdx, bitNext;
  logic [4:0]       scanIdx;
  logic frameRead, lastBit, phMid, phEnd, frameEnd, idValid;
  logic accept, scanGo, scanNext;

  always_comb begin
    frameRead = scanning | cmdRead;
    lastBit   = bitIdx == (frameRead ? RD_LAST : WR_LAST);
    phMid     = ph == PH_MID;
    phEnd     = ph == PH_END;
    frameEnd  = running && phEnd && lastBit;
    idValid   = (rxData != '0) && (rxData != '1);
    bitNext   = bitIdx + BIT_W'(1);

    accept   = !running && regWrEn && (wrRead || wrWrite);
    scanGo   = !running && !accept && scanStart;
    scanNext = frameEnd && scanning && !idValid && (scanIdx != LAST_PHY);

    stb.load    = accept || scanGo || scanNext;
    stb.rise    = running && phMid;
    stb.capture = running && phMid && frameRead && (bitIdx >= RD_FIRST_SMP);
    stb.fall    = running && phEnd && !lastBit;
    stb.finish  = frameEnd && !scanNext;
    stb.drive   = !frameRead || (bitNext < RD_DRIVEN);

    loadPhy  = accept ? wrPhy : (scanGo ? 5'd0 : scanIdx + 5'd1);
    loadReg  = accept ? wrReg : ID_REG_ADDR;
    loadRead = accept ? wrRead : 1'b1;
  end

  // Bit timing engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      ph      <= '0;
      bitIdx  <= '0;
    end else if (stb.load) begin
      running <= 1'b1;
      ph      <= '0;
      bitIdx  <= '0;
    end else if (running) begin
      if (phEnd) begin
        ph <= '0;
        if (lastBit) running <= 1'b0;
        else         bitIdx  <= bitNext;
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end

  // Software command word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPhy  <= '0;
      cmdReg  <= '0;
      cmdData <= '0;
      cmdRead <= 1'b0;
      done    <= 1'b0;
    end else if (accept) begin
      cmdPhy  <= wrPhy;
      cmdReg  <= wrReg;
      cmdData <= wrData;
      cmdRead <= wrRead;
      done    <= 1'b0;
    end else if (frameEnd && !scanning) begin
      done <= 1'b1;
      if (cmdRead) cmdData <= rxData;
    end
  end

  // Address search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanning  <= 1'b0;
      scanIdx   <= '0;
      scanDone  <= 1'b0;
      scanFound <= 1'b0;
      scanAddr  <= FALLBACK_PHY;
    end else if (scanGo) begin
      scanning  <= 1'b1;
      scanIdx   <= '0;
      scanDone  <= 1'b0;
      scanFound <= 1'b0;
    end else if (scanNext) begin
      scanIdx <= scanIdx + 5'd1;
    end else if (frameEnd && scanning) begin
      scanning  <= 1'b0;
      scanDone  <= 1'b1;
      scanFound <= idValid;
      scanAddr  <= idValid ? scanIdx : FALLBACK_PHY;
    end
  end

  assign busy = running;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV      = 10,
  parameter int PREAMBLE_LEN = 35
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        scanStart,
  output logic        scanDone,
  output logic        scanFound,
  output logic [4:0]  scanAddr,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdio_strobe_t      stb;
  logic [4:0]        loadPhy, loadReg, cmdPhy, cmdReg;
  logic              loadRead, busy, done;
  logic [DATA_W-1:0] rxData, cmdData;
  logic              unusedCmdBits;

  assign unusedCmdBits = ^regWrData[31:28];

  mdio_ctrl #(.CLK_DIV(CLK_DIV), .PREAMBLE_LEN(PREAMBLE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn),
    .wrRead(regWrData[27]), .wrWrite(regWrData[26]),
    .wrPhy(regWrData[25:21]), .wrReg(regWrData[20:16]), .wrData(regWrData[15:0]),
    .scanStart(scanStart), .rxData(rxData), .stb(stb),
    .loadPhy(loadPhy), .loadReg(loadReg), .loadRead(loadRead),
    .busy(busy), .done(done), .cmdPhy(cmdPhy), .cmdReg(cmdReg), .cmdData(cmdData),
    .scanDone(scanDone), .scanFound(scanFound), .scanAddr(scanAddr)
  );

  mdio_datapath #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .loadPhy(loadPhy), .loadReg(loadReg), .loadRead(loadRead), .loadData(regWrData[15:0]),
    .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .rxData(rxData)
  );

  assign regRdData = {2'b00, busy, done, 2'b00, cmdPhy, cmdReg, cmdData};

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [1:0] trig,
  input logic       busy,
  input logic       done,
  input logic [9:0] addrFields,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       scanDone,
  input logic       scanFound,
  input logic [4:0] scanAddr
);

  AST_CMD_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && regWrEn && (trig != 2'b00)) |=> busy); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R6

  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> ($stable(mdioOut) && $stable(mdioOe))); // R6

  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy) |-> $stable(addrFields)); // R7

  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $fell(busy)); // R8

  AST_FALLBACK_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (scanDone && !scanFound) |-> (scanAddr == 5'd1)); // R10

endmodule

bind mdio_master mdio_master_chk u_mdio_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .trig(regWrData[27:26]),
  .busy(regRdData[29]), .done(regRdData[28]), .addrFields(regRdData[25:16]),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .scanDone(scanDone), .scanFound(scanFound), .scanAddr(scanAddr)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int DIV = 2;
  localparam int PRE = 35;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        scanStart = 1'b0;
  logic        mdioIn = 1'b1;
  logic [31:0] regRdData;
  logic        scanDone, scanFound, mdc, mdioOut, mdioOe;
  logic [4:0]  scanAddr;

  always #2 clk = ~clk;

  mdio_master #(.CLK_DIV(DIV), .PREAMBLE_LEN(PRE)) i_mdio_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .scanStart(scanStart), .scanDone(scanDone),
    .scanFound(scanFound), .scanAddr(scanAddr), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int  checks = 0;
  int  failures = 0;
  bit  ended = 0;
  logic [15:0] idTab [32];

  function automatic logic [15:0] phyMem(input logic [4:0] p, input logic [4:0] r);
    return (r == 5'd3) ? idTab[p] : {r, p, 6'h2A};
  endfunction

  function automatic logic [31:0] mkCmd(input bit rd, input bit wr, input logic [4:0] p,
                                        input logic [4:0] r, input logic [15:0] d);
    return {4'b0000, rd, wr, p, r, d};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit         mBusy = 0, mScan = 0, mRead = 0, mDone = 0;
  bit         mScanDone = 0, mScanFound = 0;
  int         mK = 0;
  logic [4:0] fPhy = '0, fReg = '0, cPhy = '0, cReg = '0;
  logic [4:0] mScanAddr = 5'd1;
  logic [15:0] fData = '0, cData = '0;

  function automatic int frameLen(input bit rd);
    return rd ? PRE + 31 : PRE + 32;
  endfunction

  function automatic logic frameBit(input int idx);
    int i;
    if (idx < PRE) return 1'b1;
    i = idx - PRE;
    if (i == 0) return 1'b0;
    if (i == 1) return 1'b1;
    if (i == 2) return mRead;
    if (i == 3) return !mRead;
    if (i < 9)  return fPhy[8 - i];
    if (i < 14) return fReg[13 - i];
    if (mRead)  return 1'b1;
    if (i == 14) return 1'b1;
    if (i == 15) return 1'b0;
    return fData[31 - i];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mScan = 0; mRead = 0; mDone = 0; mK = 0;
      mScanDone = 0; mScanFound = 0; mScanAddr = 5'd1;
      cPhy = '0; cReg = '0; cData = '0;
    end else if (mBusy) begin
      mK++;
      if (mK == frameLen(mRead) * 2 * DIV) begin
        if (mScan) begin
          if (idTab[fPhy] != 16'h0000 && idTab[fPhy] != 16'hFFFF) begin
            mBusy = 0; mScan = 0; mScanDone = 1; mScanFound = 1; mScanAddr = fPhy;
          end else if (fPhy == 5'd31) begin
            mBusy = 0; mScan = 0; mScanDone = 1; mScanFound = 0; mScanAddr = 5'd1;
          end else begin
            fPhy = fPhy + 5'd1; mK = 0;
          end
        end else begin
          mBusy = 0; mDone = 1;
          if (mRead) cData = phyMem(fPhy, fReg);
        end
      end
    end else if (regWrEn && (regWrData[27] || regWrData[26])) begin
      mBusy = 1; mK = 0; mDone = 0; mRead = regWrData[27];
      fPhy = regWrData[25:21]; fReg = regWrData[20:16]; fData = regWrData[15:0];
      cPhy = fPhy; cReg = fReg; cData = fData;
    end else if (scanStart) begin
      mBusy = 1; mScan = 1; mK = 0; mRead = 1; fPhy = 5'd0; fReg = 5'd3;
      mScanDone = 0; mScanFound = 0;
    end
  end

  // Compare every cycle, away from the active edge; also play the PHY
  always @(negedge clk) begin
    if (rstN && !ended) begin
      int  bitN, ph, rdIdx;
      bit  expMdc, expOe, expOut;
      bitN   = mK / (2 * DIV);
      ph     = mK % (2 * DIV);
      expMdc = mBusy && (ph >= DIV);
      expOe  = mBusy && (!mRead || bitN < PRE + 14);
      expOut = mBusy ? frameBit(bitN) : 1'b1;
      check("R6 mdc", {31'b0, mdc}, {31'b0, expMdc});
      check(mRead ? "R5 oe" : "R4 oe", {31'b0, mdioOe}, {31'b0, expOe});
      if (expOe || !mBusy)
        check((bitN < PRE + 14) ? "R3 out" : "R4 out", {31'b0, mdioOut}, {31'b0, expOut});
      check("R2 word", regRdData, {2'b00, mBusy, mDone, 2'b00, cPhy, cReg, cData});
      check("R9 scan", {25'b0, scanDone, scanFound, scanAddr},
            {25'b0, mScanDone, mScanFound, mScanAddr});
      rdIdx = bitN - (PRE + 15);
      if (mBusy && mRead && rdIdx >= 0 && rdIdx < 16)
        mdioIn = phyMem(fPhy, fReg)[15 - rdIdx];
      else
        mdioIn = 1'b1;
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendCmd(input logic [31:0] w);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = w;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulseScan();
    @(negedge clk);
    scanStart = 1'b1;
    @(negedge clk);
    scanStart = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (regRdData[29]) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) idTab[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 word", regRdData, 32'h0);
    check("R12 pins", {29'b0, mdc, mdioOe, mdioOut}, {29'b0, 1'b0, 1'b0, 1'b1});
    check("R12 scan", {25'b0, scanDone, scanFound, scanAddr}, {25'b0, 1'b0, 1'b0, 5'd1});
    rstN = 1'b1;

    // R4 R8: write frame, done set at end
    sendCmd(mkCmd(0, 1, 5'd5, 5'h1A, 16'hA5C3));
    waitIdle();
    check("R8 write done", regRdData, {4'b0001, 2'b00, 5'd5, 5'h1A, 16'hA5C3});

    // R5 read, R7 write during busy ignored
    sendCmd(mkCmd(1, 0, 5'd19, 5'd7, 16'h0000));
    repeat (40) @(negedge clk);
    sendCmd(mkCmd(0, 1, 5'd2, 5'd2, 16'h1234));
    waitIdle();
    check("R5 read data", regRdData, {4'b0001, 2'b00, 5'd19, 5'd7, phyMem(5'd19, 5'd7)});
    check("R7 ignored while busy", {22'b0, regRdData[25:16]}, {22'b0, 5'd19, 5'd7});

    // R1 both request bits: read wins
    idTab[9] = 16'h2000;
    sendCmd(mkCmd(1, 1, 5'd9, 5'd3, 16'hFFFF));
    waitIdle();
    check("R1 both bits read", regRdData, {4'b0001, 2'b00, 5'd9, 5'd3, 16'h2000});

    // R1 neither bit: ignored
    sendCmd(mkCmd(0, 0, 5'd4, 5'd4, 16'h5555));
    @(negedge clk);
    check("R1 no trigger", regRdData, {4'b0001, 2'b00, 5'd9, 5'd3, 16'h2000});

    // R9 scan finds first valid address (6), skipping 0x0000 and 0xFFFF
    idTab[1] = 16'h0000;
    idTab[6] = 16'h0141;
    pulseScan();
    waitIdle();
    check("R9 found 6", {25'b0, scanDone, scanFound, scanAddr}, {25'b0, 1'b1, 1'b1, 5'd6});
    check("R11 word kept", regRdData, {4'b0001, 2'b00, 5'd9, 5'd3, 16'h2000});

    // R7 scan pulse while busy is ignored
    sendCmd(mkCmd(0, 1, 5'd8, 5'd1, 16'h0F0F));
    repeat (10) @(negedge clk);
    pulseScan();
    waitIdle();
    repeat (4) @(negedge clk);
    check("R7 scan ignored", {24'b0, regRdData[29], scanDone, scanFound, scanAddr},
          {24'b0, 1'b0, 1'b1, 1'b1, 5'd6});

    // R10 nothing answers: fallback address 1
    for (int i = 0; i < 32; i++) idTab[i] = (i % 2 == 0) ? 16'hFFFF : 16'h0000;
    pulseScan();
    waitIdle();
    check("R10 not found", {25'b0, scanDone, scanFound, scanAddr}, {25'b0, 1'b1, 1'b0, 5'd1});

    // R9 boundary: only the last address answers
    idTab[31] = 16'h0022;
    pulseScan();
    waitIdle();
    check("R9 found 31", {25'b0, scanDone, scanFound, scanAddr}, {25'b0, 1'b1, 1'b1, 5'd31});
    check("R11 done kept", regRdData, {4'b0001, 2'b00, 5'd8, 5'd1, 16'h0F0F});

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule